// File: doc/BRIEF.md
# Correlating Two-Level Branch Predictor

The block predicts the direction of a conditional branch. It keeps a table of 2-bit saturating counters. A lookup picks one counter by concatenating the low-order bits of the branch address with a global register that holds the outcomes of the most recent resolved branches. Each address slot therefore owns 2^HIST_W counters, and the recent global behaviour chooses which of them speaks for the branch. With HIST_W set to zero, the table becomes a plain per-address 2-bit counter table.

The fetch side presents an address and reads a taken prediction and the table index in the same cycle, through a purely combinational path. When a branch resolves, the back end drives the update port with the branch address, the real outcome and a valid strobe. On the next clock edge, the selected counter moves one step toward the outcome. The history register then shifts the outcome in. The counter update uses the history as it stood before that shift. Table entries carry no tag, so branches whose low address bits match share counters.

Top module: `corr_bpred`

## Requirements
- R1: After reset, every counter holds 01 (weakly not taken) and the history register is zero, so every lookup predicts not taken.
- R2: The table index is {address[IDX_W-1:0], history}, with the history in the least significant HIST_W bits. With the default IDX_W=6 and HIST_W=2 this is 8 bits. The index is presented on pred_idx_o.
- R3: pred_taken_o equals the most significant bit of the selected counter. Counter values 10 and 11 predict taken.
- R4: A valid update increments the selected counter for a taken outcome and decrements it for a not-taken outcome. The counter saturates at 11 and at 00.
- R5: A counter at 11 still predicts taken after one not-taken update. Two consecutive not-taken updates to that counter are needed to flip the prediction. The same holds symmetrically from 00.
- R6: A valid update shifts the actual outcome into bit 0 of the history and drops the oldest bit. The counter changed by that update is the one indexed with the history before the shift.
- R7: A valid update modifies only the counter it selects. Counters for the same address under other history patterns, and for other addresses, are unchanged.
- R8: Addresses that differ only above bit IDX_W-1 map to the same counters.
- R9: When a lookup and an update select the same counter in one cycle, the lookup returns the counter value from before the update.
- R10: While upd_valid_i is low, neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_addr_i | input | ADDR_W | Lookup branch address |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_idx_o | output | IDX_W+HIST_W | Counter index used by the lookup |
| upd_valid_i | input | 1 | Resolved-branch update strobe |
| upd_addr_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench targets several corner cases:
- **History ordering.** It drives an outcome sequence that revisits a counter at 11 with one not-taken update between two runs of taken updates. A design that indexed the update with the already-shifted history would move the wrong counter, and the later lookup would predict differently from the model.
- **Saturation.** It pushes counters past both ends. A wrapping counter would flip straight to the opposite strong state.
- **Same-cycle hazard.** It aims lookups at the counter being written in the same cycle, which exposes a design that forwards the new value.
- **Aliasing.** It uses addresses that alias above the index bits, which exposes any address check or mis-sliced index.
- **Ignored updates.** It presents idle cycles with live update data, which catches state that changes without the strobe.

// File: rtl/corr_bpred_pkg.sv
package corr_bpred_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;

  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    if (taken) return (cur == 2'b11) ? cur : cur + 2'b01;
    else       return (cur == 2'b00) ? cur : cur - 2'b01;
  endfunction
endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int HIST_W = 2,
  localparam int HW = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [HW-1:0] hist_o
);
  generate
    if (HIST_W > 1) begin : g_multi
      logic [HW-1:0] hist_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= '0;
        else if (shift_i) hist_q <= {hist_q[HW-2:0], bit_i};
      end
      assign hist_o = hist_q;

      // R6
      hist_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |=> hist_o[0] == $past(bit_i));
      // R10
      hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_i |=> $stable(hist_o));
    end else if (HIST_W == 1) begin : g_one
      logic hist_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= 1'b0;
        else if (shift_i) hist_q <= bit_i;
      end
      assign hist_o = hist_q;
    end else begin : g_none
      logic unused_in;
      assign unused_in = shift_i ^ bit_i;
      assign hist_o    = '0;
    end
  endgenerate
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 2,
  localparam int HW = (HIST_W > 0) ? HIST_W : 1,
  localparam int IW = IDX_W + HIST_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HW-1:0]     hist_i,
  output logic [IW-1:0]     idx_o
);
  // no tag: upper address bits never reach the table
  logic unused_hi;
  assign unused_hi = ^addr_i[ADDR_W-1:IDX_W];

  generate
    if (HIST_W > 0) begin : g_corr
      assign idx_o = {addr_i[IDX_W-1:0], hist_i};
    end else begin : g_flat
      logic unused_hist;
      assign unused_hist = ^hist_i;
      assign idx_o = addr_i[IDX_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import corr_bpred_pkg::*;
#(
  parameter int IW = 8,
  localparam int DEPTH = 1 << IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  output ctr_t          rd_o,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          taken_i
);
  ctr_t mem [DEPTH];
  ctr_t wr_cur;

  assign wr_cur = mem[wr_idx_i];
  // read sees stored value; a same-cycle write lands at the edge
  assign rd_o   = mem[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (we_i) begin
      mem[wr_idx_i] <= ctr_next(wr_cur, taken_i);
    end
  end

  // R4
  ctr_sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && taken_i && wr_cur == 2'b11) |=> mem[$past(wr_idx_i)] == 2'b11);
  // R4
  ctr_sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !taken_i && wr_cur == 2'b00) |=> mem[$past(wr_idx_i)] == 2'b00);
  // R7
  ctr_other_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_idx_i != rd_idx_i) |=> mem[$past(rd_idx_i)] == $past(rd_o));
  // R10
  ctr_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> mem[$past(rd_idx_i)] == $past(rd_o));
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import corr_bpred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 2,
  localparam int HW = (HIST_W > 0) ? HIST_W : 1,
  localparam int IW = IDX_W + HIST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              pred_taken_o,
  output logic [IW-1:0]     pred_idx_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic              upd_taken_i
);
  logic [HW-1:0] hist;
  logic [IW-1:0] lk_idx, upd_idx;
  ctr_t          lk_ctr;

  bp_ghr #(.HIST_W(HIST_W)) ghr_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .bit_i   (upd_taken_i),
    .hist_o  (hist)
  );

  bp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) lk_index_i (
    .addr_i (lk_addr_i),
    .hist_i (hist),
    .idx_o  (lk_idx)
  );

  // update uses the pre-shift history
  bp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) upd_index_i (
    .addr_i (upd_addr_i),
    .hist_i (hist),
    .idx_o  (upd_idx)
  );

  bp_ctr_table #(.IW(IW)) table_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (lk_idx),
    .rd_o     (lk_ctr),
    .we_i     (upd_valid_i),
    .wr_idx_i (upd_idx),
    .taken_i  (upd_taken_i)
  );

  assign pred_taken_o = lk_ctr[1];
  assign pred_idx_o   = lk_idx;

  // R10
  pred_idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_valid_i && $stable(lk_addr_i)) |=> (!$stable(lk_addr_i) || $stable(pred_taken_o)));
endmodule

// File: tb/corr_bpred_tb_top.sv
`timescale 1ns/1ps
module corr_bpred_tb_top;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 6;
  localparam int HIST_W = 2;
  localparam int IW     = IDX_W + HIST_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] lk_addr_i = '0;
  logic              pred_taken_o;
  logic [IW-1:0]     pred_idx_o;
  logic              upd_valid_i = 1'b0;
  logic [ADDR_W-1:0] upd_addr_i = '0;
  logic              upd_taken_i = 1'b0;

  corr_bpred #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) dut_i (
    .clk_i, .rst_ni, .lk_addr_i, .pred_taken_o, .pred_idx_o,
    .upd_valid_i, .upd_addr_i, .upd_taken_i
  );

  always #10 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  int ref_ctr [1 << IW];
  int ref_hist = 0;
  bit done = 1'b0;

  function automatic int ref_idx(input logic [ADDR_W-1:0] a);
    return (int'(a[IDX_W-1:0]) << HIST_W) | ref_hist;
  endfunction

  task automatic step(input logic [ADDR_W-1:0] la, input bit v,
                      input logic [ADDR_W-1:0] ua, input bit t, input string tag);
    int ei, ui;
    bit ep;
    @(negedge clk_i);
    lk_addr_i = la; upd_valid_i = v; upd_addr_i = ua; upd_taken_i = t;
    #2;
    ei = ref_idx(la);
    ep = ref_ctr[ei] >= 2;
    checks++;
    if (pred_idx_o !== IW'(ei) || pred_taken_o !== ep) begin
      fails++;
      $display("FAIL %s: idx=%0d pred=%0b expected idx=%0d pred=%0b",
               tag, pred_idx_o, pred_taken_o, ei, ep);
    end
    if (v) begin
      ui = ref_idx(ua);
      if (t && ref_ctr[ui] < 3) ref_ctr[ui]++;
      if (!t && ref_ctr[ui] > 0) ref_ctr[ui]--;
      ref_hist = ((ref_hist << 1) | int'(t)) & ((1 << HIST_W) - 1);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R1: watchdog expired, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << IW); i++) ref_ctr[i] = 1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: every slot predicts not taken after reset
    for (int a = 0; a < (1 << IDX_W); a++) step(a, 1'b0, '0, 1'b0, "R1");

    // R3 R4: taken updates on address 5 until the history settles at 11 and the counter saturates
    for (int k = 0; k < 6; k++) step(32'd5, 1'b1, 32'd5, 1'b1, "R4");
    step(32'd5, 1'b0, '0, 1'b0, "R3");
    // R5: one not-taken at history 11, refill history, then look again
    step(32'd5, 1'b1, 32'd5, 1'b0, "R5");
    step(32'd9, 1'b1, 32'd9, 1'b1, "R6");
    step(32'd9, 1'b1, 32'd9, 1'b1, "R6");
    step(32'd5, 1'b0, '0, 1'b0, "R5");
    // R7: other history patterns of address 5 untouched
    step(32'd5, 1'b1, 32'd9, 1'b0, "R7");
    step(32'd5, 1'b0, '0, 1'b0, "R7");
    // R8: aliased addresses share counters
    step(32'd5 + 32'd64, 1'b0, '0, 1'b0, "R8");
    step(32'h8000_0045, 1'b0, '0, 1'b0, "R8");
    // R9: lookup and update on the same counter in one cycle
    for (int k = 0; k < 4; k++) step(32'd12, 1'b1, 32'd12, k[0], "R9");
    // R10: live update data with the strobe low
    for (int k = 0; k < 4; k++) step(32'd12, 1'b0, 32'd12, 1'b1, "R10");
    // R4: drive a counter to the floor
    for (int k = 0; k < 6; k++) step(32'd20, 1'b1, 32'd20, 1'b0, "R4");
    step(32'd20, 1'b0, '0, 1'b0, "R4");

    // R2 R6: random traffic over a small address pool
    for (int k = 0; k < 4000; k++) begin
      logic [ADDR_W-1:0] la, ua;
      ua = ($urandom_range(0, 3) * 64) + $urandom_range(0, 7);
      la = ($urandom_range(0, 3) == 0) ? ua : ($urandom_range(0, 3) * 64) + $urandom_range(0, 7);
      step(la, $urandom_range(0, 3) != 0, ua, $urandom_range(0, 2) != 0, "R2");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule